// File: doc/BRIEF.md
# Control/Status Register Access Guard

This block stands between an instruction decoder and a control/status register file. For each access it receives a 12-bit register address, the current privilege level, the access kind and a source operand. It returns one verdict: legal or illegal. For a legal access it also produces a merged write toward the register file. It returns the register's previous contents to the requester in every legal case.

Legality is settled in three stages:

- **Address rules.** Two rules come from the address alone: a minimum privilege level, and a read-only region.
- **Gates on some registers.** Floating-point registers are refused while the floating-point unit is switched off, unless a debugger is making the access. User counter registers pass through a counter-enable mask with two levels, one set by machine mode and one set by supervisor mode.
- **Implemented addresses.** An address that the register file does not implement is always refused.

Requests arrive on a valid/ready channel and responses leave on a valid/ready channel. Only one access is in flight at a time:

- A request is accepted only while no response is pending, that is, while `req_ready` is high.
- The response appears in the cycle after the request is accepted.
- The response is held unchanged until the consumer raises `rsp_ready`.
- Request fields may change freely while `req_ready` is low.

The register file is read combinationally through `rf_raddr`/`rf_rdata`/`rf_hit`. It is written through a strobe that lasts one cycle and rises together with the response.

Top module: `csr_access_guard`

## Requirements
- R1: Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine. An access is illegal when the privilege level is numerically below address bits [9:8].
- R2: An address whose bits [11:10] are 2'b11 is read-only. An access to it with a nonzero write mask is illegal. With a zero mask, the same access is legal.
- R3: The kind encoding sets the write mask and data as follows:
  - 0 is a plain read: mask 0.
  - 1 is a swap: mask all ones, data = operand.
  - 2 is a bit set: mask = operand, data all ones.
  - 3 is a bit clear: mask = operand, data 0.
- R4: The written value is (old & ~mask) | (data & mask). `rsp_rdata` carries the old value on a legal access and zero on an illegal one.
- R5: User counter addresses are 0xC00–0xC1F and 0xC80–0xC9F. For these, an enable vector starts as all ones. Below machine level it is ANDed with `mcounter_en`. Below supervisor level it is also ANDed with `scounter_en`. The access is legal only if bit address[4:0] of the result is 1.
- R6: The floating-point addresses are 0x001–0x003. Accesses to them are illegal when `fs_state` is 0, unless `dbg_access` is 1.
- R7: A write to a floating-point address that raises `rf_we` also pulses `fs_dirty_set` in the same cycle. This pulse asks for the status field to be set to dirty (2'b11).
- R8: An access is illegal when `rf_hit` is 0.
- R9: `rf_we` is raised only for a legal access with a nonzero mask. It lasts exactly one cycle and carries the address and merged value in `rf_waddr`/`rf_wdata`.
- R10: A request is accepted when `req_valid` and `req_ready` are both high, and `req_ready` equals `!rsp_valid`. The response is registered one cycle after acceptance and holds stable until `rsp_ready` is high.
- R11: After reset, `rsp_valid`, `rf_we` and `fs_dirty_set` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 12 | Register address |
| req_priv | input | 2 | Current privilege level |
| req_kind | input | 2 | Access kind (read, swap, set, clear) |
| req_operand | input | XLEN | Source operand |
| dbg_access | input | 1 | Debugger access, bypasses the floating-point gate |
| fs_state | input | 2 | Floating-point status field |
| mcounter_en | input | CNT_N | Machine-level counter enables |
| scounter_en | input | CNT_N | Supervisor-level counter enables |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_illegal | output | 1 | Access refused |
| rsp_rdata | output | XLEN | Old register value (zero when refused) |
| rf_raddr | output | 12 | Register file read address |
| rf_rdata | input | XLEN | Register file read data |
| rf_hit | input | 1 | Address is implemented |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 12 | Write address |
| rf_wdata | output | XLEN | Merged write value |
| fs_dirty_set | output | 1 | Request to mark floating-point state dirty |

## Verification
Two outputs share the cycle after an accepted access: the one-cycle write strobe (with the dirty pulse for floating-point writes) and the response, which may be held under back-pressure.

The bench provokes this overlap by:
- issuing a floating-point swap with a debugger bypass;
- withholding `rsp_ready` for several cycles.

It then judges the result in three steps:
- The strobe, merged value and dirty pulse must appear exactly once, in the first cycle.
- The response and the blocked `req_ready` must stay frozen over all the held cycles.
- A following access must see no repeated write.

// File: rtl/csr_guard_pkg.sv
package csr_guard_pkg;
  localparam int unsigned ADDR_W = 12;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_SWAP  = 2'd1,
    KIND_SET   = 2'd2,
    KIND_CLEAR = 2'd3
  } kind_e;

  localparam logic [1:0] FS_OFF   = 2'b00;
  localparam logic [1:0] FS_DIRTY = 2'b11;

  localparam logic [6:0] CNT_LO_PAGE = 7'h60;  // 0xC00..0xC1F
  localparam logic [6:0] CNT_HI_PAGE = 7'h64;  // 0xC80..0xC9F

  function automatic logic addr_is_fp(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:2] == '0) && (a[1:0] != 2'b00);
  endfunction

  function automatic logic addr_is_readonly(input logic [ADDR_W-1:0] a);
    return a[11:10] == 2'b11;
  endfunction
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_guard_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      kind,
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] wmask,
  output logic [XLEN-1:0] wval,
  output logic            mask_nz
);
  kind_e k;

  always_comb begin
    k = kind_e'(kind);
    unique case (k)
      KIND_READ: begin
        wmask = '0;
        wval  = '0;
      end
      KIND_SWAP: begin
        wmask = '1;
        wval  = operand;
      end
      KIND_SET: begin
        wmask = operand;
        wval  = '1;
      end
      default: begin
        wmask = operand;
        wval  = '0;
      end
    endcase
    mask_nz = |wmask;
  end
endmodule

// File: rtl/csr_perm_check.sv
module csr_perm_check
  import csr_guard_pkg::*;
#(
  parameter int unsigned CNT_N  = 32,
  parameter bit          HI_CNT = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        priv,
  input  logic              mask_nz,
  input  logic              hit,
  input  logic [1:0]        fs,
  input  logic              dbg,
  input  logic [CNT_N-1:0]  men,
  input  logic [CNT_N-1:0]  sen,
  output logic              illegal,
  output logic              is_fp
);
  localparam int unsigned IDX_W = (CNT_N > 1) ? $clog2(CNT_N) : 1;

  logic             is_cnt;
  logic [CNT_N-1:0] cnt_en;
  logic             cnt_ok;
  logic             priv_low;
  logic             ro_viol;
  logic             fs_ok;

  generate
    if (HI_CNT) begin : g_both_pages
      assign is_cnt = (addr[11:5] == CNT_LO_PAGE) || (addr[11:5] == CNT_HI_PAGE);
    end else begin : g_low_page
      assign is_cnt = (addr[11:5] == CNT_LO_PAGE);
    end
  endgenerate

  always_comb begin
    cnt_en = '1;
    if (priv < PRIV_MACH)  cnt_en = cnt_en & men;
    if (priv < PRIV_SUPER) cnt_en = cnt_en & sen;
    cnt_ok = cnt_en[addr[IDX_W-1:0]];
  end

  assign priv_low = priv < addr[9:8];
  assign ro_viol  = addr_is_readonly(addr) && mask_nz;
  assign is_fp    = addr_is_fp(addr);
  assign fs_ok    = (fs != FS_OFF) || dbg;
  assign illegal  = !hit || priv_low || ro_viol
                  || (is_cnt && !cnt_ok) || (is_fp && !fs_ok);
endmodule

// File: rtl/csr_merge.sv
module csr_merge #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wmask,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] merged
);
  assign merged = (old_val & ~wmask) | (wval & wmask);
endmodule

// File: rtl/csr_access_guard.sv
module csr_access_guard
  import csr_guard_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CNT_N  = 32,
  parameter bit          HI_CNT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [11:0]       req_addr,
  input  logic [1:0]        req_priv,
  input  logic [1:0]        req_kind,
  input  logic [XLEN-1:0]   req_operand,
  input  logic              dbg_access,
  input  logic [1:0]        fs_state,
  input  logic [CNT_N-1:0]  mcounter_en,
  input  logic [CNT_N-1:0]  scounter_en,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_illegal,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic [11:0]       rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  input  logic              rf_hit,
  output logic              rf_we,
  output logic [11:0]       rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              fs_dirty_set
);
  logic [XLEN-1:0] wmask, wval, merged;
  logic            mask_nz, illegal, is_fp, accept, do_write;

  csr_op_decode #(.XLEN(XLEN)) u_dec (
    .kind(req_kind), .operand(req_operand),
    .wmask(wmask), .wval(wval), .mask_nz(mask_nz)
  );

  csr_perm_check #(.CNT_N(CNT_N), .HI_CNT(HI_CNT)) u_perm (
    .addr(req_addr), .priv(req_priv), .mask_nz(mask_nz), .hit(rf_hit),
    .fs(fs_state), .dbg(dbg_access), .men(mcounter_en), .sen(scounter_en),
    .illegal(illegal), .is_fp(is_fp)
  );

  csr_merge #(.XLEN(XLEN)) u_merge (
    .old_val(rf_rdata), .wmask(wmask), .wval(wval), .merged(merged)
  );

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign do_write  = accept && !illegal && mask_nz;
  assign rf_raddr  = req_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_illegal  <= 1'b0;
      rsp_rdata    <= '0;
      rf_we        <= 1'b0;
      rf_waddr     <= '0;
      rf_wdata     <= '0;
      fs_dirty_set <= 1'b0;
    end else begin
      rf_we        <= do_write;
      fs_dirty_set <= do_write && is_fp;
      if (accept) begin
        rsp_valid   <= 1'b1;
        rsp_illegal <= illegal;
        rsp_rdata   <= illegal ? '0 : rf_rdata;
        rf_waddr    <= req_addr;
        rf_wdata    <= merged;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csr_access_guard_chk.sv
module csr_access_guard_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [11:0]     req_addr,
  input logic [1:0]      req_priv,
  input logic [1:0]      req_kind,
  input logic            rf_hit,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_illegal,
  input logic [XLEN-1:0] rsp_rdata,
  input logic            rf_we,
  input logic            fs_dirty_set
);
  a_r1_low_priv_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_priv < req_addr[9:8])) |=> rsp_illegal);

  a_r2_readonly_swap_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[11:10] == 2'b11 && req_kind == 2'd1) |=> rsp_illegal);

  a_r8_unimplemented_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !rf_hit) |=> rsp_illegal);

  a_r9_no_write_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rsp_valid && !rsp_illegal));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  a_r7_dirty_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    fs_dirty_set |-> rf_we);

  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r10_response_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_illegal) && $stable(rsp_rdata)));
endmodule

bind csr_access_guard csr_access_guard_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_priv(req_priv), .req_kind(req_kind), .rf_hit(rf_hit),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_illegal(rsp_illegal),
  .rsp_rdata(rsp_rdata), .rf_we(rf_we), .fs_dirty_set(fs_dirty_set)
);

// File: tb/sim_csr_access_guard.sv
module sim_csr_access_guard;
  localparam int XLEN = 32;
  localparam int NV   = 20;
  // entry: addr[22:11] priv[10:9] kind[8:7] opsel[6:5] hit[4] fs[3:2] dbg[1] exp_illegal[0]
  localparam logic [22:0] VEC [NV] = '{
    {12'h300, 2'd3, 2'd1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0},  // R1 machine swap ok
    {12'h300, 2'd1, 2'd1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b1},  // R1 super too low
    {12'h300, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1},  // R1 user read too low
    {12'h100, 2'd1, 2'd1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0},  // R1 super on super reg
    {12'hF11, 2'd3, 2'd0, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0},  // R2 read-only read
    {12'hF11, 2'd3, 2'd1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b1},  // R2 read-only swap
    {12'hF11, 2'd3, 2'd2, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0},  // R2 set with zero mask
    {12'hC00, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0},  // R5 bit0 enabled
    {12'hC01, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1},  // R5 machine mask
    {12'hC01, 2'd1, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1},  // R5 machine mask at super
    {12'hC02, 2'd1, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0},  // R5 super mask ignored at super
    {12'hC02, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1},  // R5 super mask at user
    {12'hC01, 2'd3, 2'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0},  // R5 machine bypass
    {12'h001, 2'd0, 2'd1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b1},  // R6 fp off
    {12'h001, 2'd0, 2'd1, 2'd1, 1'b1, 2'd0, 1'b1, 1'b0},  // R6 debugger bypass
    {12'h002, 2'd0, 2'd2, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0},  // R7 fp set
    {12'h340, 2'd3, 2'd3, 2'd2, 1'b0, 2'd0, 1'b0, 1'b1},  // R8 unimplemented
    {12'h340, 2'd3, 2'd3, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0},  // R3 clear
    {12'hC00, 2'd0, 2'd1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b1},  // R2 counter swap read-only
    {12'hC81, 2'd3, 2'd0, 2'd0, 1'b1, 2'd3, 1'b0, 1'b0}   // R5 high page
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0, dbg_access = 1'b0, rf_hit = 1'b1;
  logic [11:0] req_addr = '0;
  logic [1:0] req_priv = '0, req_kind = '0, fs_state = '0;
  logic [XLEN-1:0] req_operand = '0, rf_rdata = '0;
  logic [31:0] mcounter_en = 32'hFFFF_FFFD, scounter_en = 32'hFFFF_FFFB;
  logic req_ready, rsp_valid, rsp_illegal, rf_we, fs_dirty_set;
  logic [XLEN-1:0] rsp_rdata, rf_wdata;
  logic [11:0] rf_raddr, rf_waddr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  csr_access_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_priv(req_priv), .req_kind(req_kind),
    .req_operand(req_operand), .dbg_access(dbg_access), .fs_state(fs_state),
    .mcounter_en(mcounter_en), .scounter_en(scounter_en), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_hit(rf_hit), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .fs_dirty_set(fs_dirty_set)
  );

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] model_wdata(input logic [1:0] k,
      input logic [XLEN-1:0] op, input logic [XLEN-1:0] old);
    logic [XLEN-1:0] m, d;
    case (k)
      2'd0: begin m = '0; d = '0; end
      2'd1: begin m = '1; d = op; end
      2'd2: begin m = op; d = '1; end
      default: begin m = op; d = '0; end
    endcase
    return (old & ~m) | (d & m);
  endfunction

  function automatic logic model_masknz(input logic [1:0] k, input logic [XLEN-1:0] op);
    return (k == 2'd1) || ((k != 2'd0) && (op != '0));
  endfunction

  // drive one request at a negedge; results sampled at the next negedge
  task automatic issue(input logic [11:0] a, input logic [1:0] p, input logic [1:0] k,
      input logic [XLEN-1:0] op, input logic [XLEN-1:0] old, input logic hit,
      input logic [1:0] fs, input logic dbg);
    req_addr = a; req_priv = p; req_kind = k; req_operand = op;
    rf_rdata = old; rf_hit = hit; fs_state = fs; dbg_access = dbg;
    req_valid = 1'b1; rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic release_rsp();
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rsp_valid after reset", rsp_valid, 0);
    chk("R11 rf_we after reset", rf_we, 0);
    chk("R11 fs_dirty_set after reset", fs_dirty_set, 0);
    chk("R11 req_ready after reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] a;
      logic [1:0] p, k, sel, fs;
      logic hit, dbg, ill, we, fp;
      logic [XLEN-1:0] op, old;
      {a, p, k, sel, hit, fs, dbg, ill} = VEC[i];
      op  = (sel == 2'd0) ? '0 : (sel == 2'd2) ? '1 : (32'h0F0F_3C3C ^ XLEN'(i));
      old = 32'hA5A5_5A5A + XLEN'(i) * 32'h0000_1111;
      we  = !ill && model_masknz(k, op);
      fp  = (a >= 12'h001) && (a <= 12'h003);
      issue(a, p, k, op, old, hit, fs, dbg);
      chk("R10 response valid", rsp_valid, 1);
      chk("R1 R2 R5 R6 R8 legality verdict", rsp_illegal, ill);
      chk("R4 old value returned", rsp_rdata, ill ? '0 : old);
      chk("R9 write strobe", rf_we, we);
      chk("R7 dirty pulse", fs_dirty_set, we && fp);
      if (we) begin
        chk("R3 R4 merged write data", rf_wdata, model_wdata(k, op, old));
        chk("R9 write address", rf_waddr, a);
      end
      release_rsp();
    end

    // R10 back-pressure with a coinciding floating-point write
    issue(12'h003, 2'd0, 2'd1, 32'h0000_00E5, 32'h0000_0011, 1'b1, 2'd0, 1'b1);
    chk("R7 dirty with fp write", fs_dirty_set, 1);
    chk("R3 swap data", rf_wdata, 32'h0000_00E5);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R10 held valid", rsp_valid, 1);
      chk("R10 held data", rsp_rdata, 32'h0000_0011);
      chk("R10 ready low while busy", req_ready, 0);
      chk("R9 strobe lasts one cycle", rf_we, 0);
    end
    req_valid = 1'b1;  // ignored while busy
    @(negedge clk);
    chk("R10 no accept while busy", rf_we, 0);
    req_valid = 1'b0;
    release_rsp();
    chk("R10 released", rsp_valid, 0);

    // R5 all enables cleared: even counter 0 refused at user level
    mcounter_en = 32'h0;
    issue(12'hC00, 2'd0, 2'd0, '0, 32'h5, 1'b1, 2'd0, 1'b0);
    chk("R5 cleared machine mask", rsp_illegal, 1);
    release_rsp();
    // R2 clear with zero operand on read-only register is legal and writes nothing
    issue(12'hC80, 2'd3, 2'd3, '0, 32'h77, 1'b1, 2'd0, 1'b0);
    chk("R2 zero-mask clear legal", rsp_illegal, 0);
    chk("R9 zero mask no strobe", rf_we, 0);
    release_rsp();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule